// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit operands and an incoming carry in purely combinational logic. It returns the 16-bit sum and the outgoing carry. The operands are split into four 4-bit slices. Each slice forms a generate term (AND) and a propagate term (OR) for every bit. It resolves its three internal carries by lookahead and then reduces itself to a single slice generate and a single slice propagate, with no slice carry-out. A second lookahead stage of the same form takes the four slice pairs and the incoming carry. From them it derives the carry entering slices 1 to 3 and the final carry-out. No lookahead gate in either stage needs more than four inputs.

A build parameter selects how carries pass between slices. The default resolves them through the second lookahead stage. The alternative chains them slice to slice, and both forms must produce the same outputs. The adder is intended for a datapath that needs a fast, flag-free sum. Overflow, zero detection and pipelining belong to the surrounding logic.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, with all three values taken as unsigned.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: In a 4-bit slice, the slice sum equals the low 4 bits of `a + b + c_in`. The slice propagate is 1 exactly when every one of the four bit positions has at least one operand bit set (per-bit propagate is the OR of the two operand bits).
- R4: A slice's generate is 1 exactly when the 4-bit addition of the two slice operands carries out with an incoming carry of 0. When the generate is 1, the carry leaving that slice is 1 whatever the slice's incoming carry is.
- R5: The slice-to-slice chained variant (`LOOKAHEAD_LINK = 0`) produces the same `sum` and `carry_out` as the default variant for every input.
- R6: The carry entering slice k+1 equals slice k's generate OR (slice k's propagate AND the carry entering slice k). The carry entering slice 0 is `carry_in`, and the carry leaving slice 3 is `carry_out`.
- R7: All ones plus a carry-in of 1 gives `sum` = 0 and `carry_out` = 1. Alternating patterns 0xAAAA + 0x5555 give 0xFFFF with no carry, or 0x0000 with a carry when `carry_in` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Within one evaluation a slice can both generate a carry and pass an incoming one through. A carry produced in slice 0 can also travel across every higher slice in the same evaluation, so the second lookahead stage's generate and propagate paths are active together. The bench provokes this with all-ones plus a carry, with equal all-ones slices where generate and propagate are both 1, and with the alternating patterns that hold every propagate high. Each result is compared against an integer sum computed in the bench and against the chained variant. One 4-bit slice is also swept over all 512 input combinations, with its generate and propagate judged against arithmetic and bitwise definitions.

// File: rtl/cla_pkg.sv
// Package: shared sizing for the two-level lookahead adder.
// Assumes the total width is an exact multiple of the slice width.
package cla_pkg;
    localparam int SLICE_W   = 4;
    localparam int NUM_SLICE = 4;
    localparam int SUM_W     = SLICE_W * NUM_SLICE;
endpackage

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Resolves the carry entering each of N positions from per-position
// generate/propagate terms and an incoming carry, and reduces the group to
// one generate and one propagate. The group carry-out is not produced here,
// which keeps every product term to at most N inputs.
// Assumes N is small (four in this design) because the terms are flat.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         c_in,
    output logic [N-1:0] carry,
    output logic         grp_gen,
    output logic         grp_prop
);

    // Flat sum-of-products for the carry entering each position.
    always_comb begin : carry_terms
        logic term;
        carry = '0;
        carry[0] = c_in;
        for (int i = 1; i < N; i++) begin
            term = c_in;
            for (int j = 0; j < i; j++) begin
                term = term & prop[j];
            end
            carry[i] = term;
            for (int j = 0; j < i; j++) begin
                term = gen[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & prop[k];
                end
                carry[i] = carry[i] | term;
            end
        end
    end

    // Group generate: a carry born in some position survives to the top.
    always_comb begin : group_gen_terms
        logic term;
        grp_gen = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen[j];
            for (int k = j + 1; k < N; k++) begin
                term = term & prop[k];
            end
            grp_gen = grp_gen | term;
        end
    end

    // Group propagate: every position passes an incoming carry.
    assign grp_prop = &prop;

endmodule

// File: rtl/cla_slice.sv
// Module: cla_slice
// One lookahead slice: per-bit generate (AND) and propagate (OR), internal
// carries from cla_lookahead, sum bits as a XOR b XOR carry. Emits slice
// generate/propagate instead of a carry-out.
// Assumes the caller forms the carry leaving the slice as G | P & c_in.
module cla_slice #(
    parameter int W = cla_pkg::SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    output logic [W-1:0] s,
    output logic         slice_g,
    output logic         slice_p
);

    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W-1:0] bit_c;

    // Per-bit generate and propagate.
    assign bit_g = a & b;
    assign bit_p = a | b;

    cla_lookahead #(.N(W)) u_look (
        .gen     (bit_g),
        .prop    (bit_p),
        .c_in    (c_in),
        .carry   (bit_c),
        .grp_gen (slice_g),
        .grp_prop(slice_p)
    );

    // Sum needs XOR because the propagate term is an OR.
    assign s = a ^ b ^ bit_c;

endmodule

// File: rtl/cla_adder16.sv
// Module: cla_adder16
// Combinational adder built from NUM_SLICE lookahead slices. With
// LOOKAHEAD_LINK = 1 a second cla_lookahead stage resolves the slice
// carries; with 0 they are chained slice to slice. Both give equal outputs.
// Assumes SUM_W = SLICE_W * NUM_SLICE. No clock and no reset: pure logic.
module cla_adder16 #(
    parameter int SLICE_W        = cla_pkg::SLICE_W,
    parameter int NUM_SLICE      = cla_pkg::NUM_SLICE,
    parameter bit LOOKAHEAD_LINK = 1'b1
) (
    input  logic [SLICE_W*NUM_SLICE-1:0] op_a,
    input  logic [SLICE_W*NUM_SLICE-1:0] op_b,
    input  logic                         carry_in,
    output logic [SLICE_W*NUM_SLICE-1:0] sum,
    output logic                         carry_out
);

    localparam int SUM_W = SLICE_W * NUM_SLICE;

    logic [NUM_SLICE-1:0] blk_g;
    logic [NUM_SLICE-1:0] blk_p;
    logic [NUM_SLICE:0]   blk_c;    // carry entering each slice, top = carry-out

    // Slice array.
    genvar k;
    generate
        for (k = 0; k < NUM_SLICE; k++) begin : g_slice
            cla_slice #(.W(SLICE_W)) u_slice (
                .a      (op_a[k*SLICE_W +: SLICE_W]),
                .b      (op_b[k*SLICE_W +: SLICE_W]),
                .c_in   (blk_c[k]),
                .s      (sum[k*SLICE_W +: SLICE_W]),
                .slice_g(blk_g[k]),
                .slice_p(blk_p[k])
            );
        end

        if (LOOKAHEAD_LINK) begin : g_link_look
            logic [NUM_SLICE-1:0] link_c;
            logic                 all_g;
            logic                 all_p;

            cla_lookahead #(.N(NUM_SLICE)) u_link (
                .gen     (blk_g),
                .prop    (blk_p),
                .c_in    (carry_in),
                .carry   (link_c),
                .grp_gen (all_g),
                .grp_prop(all_p)
            );

            // Slice carries from the second stage; carry-out from group terms.
            assign blk_c[NUM_SLICE-1:0] = link_c;
            assign blk_c[NUM_SLICE]     = all_g | (all_p & carry_in);
        end else begin : g_link_chain
            // Chained variant: each slice carry feeds the next.
            assign blk_c[0] = carry_in;
            for (k = 0; k < NUM_SLICE; k++) begin : g_hop
                assign blk_c[k+1] = blk_g[k] | (blk_p[k] & blk_c[k]);
            end
        end
    endgenerate

    assign carry_out = blk_c[NUM_SLICE];

endmodule

// File: rtl/cla_adder16_chk.sv
// Module: cla_adder16_chk
// Checker bound into every cla_adder16 instance. Compares the outputs with
// an arithmetic total and relates the slice carries to the slice terms.
// Uses immediate assertions because the adder has no clock.
module cla_adder16_chk #(
    parameter int SLICE_W   = 4,
    parameter int NUM_SLICE = 4
) (
    input logic [SLICE_W*NUM_SLICE-1:0] op_a,
    input logic [SLICE_W*NUM_SLICE-1:0] op_b,
    input logic                         carry_in,
    input logic [SLICE_W*NUM_SLICE-1:0] sum,
    input logic                         carry_out,
    input logic [NUM_SLICE-1:0]         blk_g,
    input logic [NUM_SLICE-1:0]         blk_p,
    input logic [NUM_SLICE:0]           blk_c
);

    localparam int SUM_W = SLICE_W * NUM_SLICE;

    logic [SUM_W:0] total;

    // Arithmetic reference total.
    assign total = {1'b0, op_a} + {1'b0, op_b} + {{SUM_W{1'b0}}, carry_in};

    // Output and carry-chain relations.
    always_comb begin : chk_relations
        p_sum_r1: assert (sum == total[SUM_W-1:0]);
        p_cout_r2: assert (carry_out == total[SUM_W]);
        p_entry_r6: assert (blk_c[0] == carry_in);
        for (int i = 0; i < NUM_SLICE; i++) begin
            p_link_r6: assert (blk_c[i+1] == (blk_g[i] | (blk_p[i] & blk_c[i])));
            p_gen_carry_r4: assert (!blk_g[i] || blk_c[i+1]);
        end
    end

endmodule

bind cla_adder16 cla_adder16_chk #(
    .SLICE_W  (SLICE_W),
    .NUM_SLICE(NUM_SLICE)
) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum      (sum),
    .carry_out(carry_out),
    .blk_g    (blk_g),
    .blk_p    (blk_p),
    .blk_c    (blk_c)
);

// File: tb/cla_adder16_tb.sv
// Bench: cla_adder16_tb
// Drives vectors on the rising edge and compares the lookahead adder, the
// chained variant and a lone slice against integer results at the falling edge.
module cla_adder16_tb;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic [W-1:0] a, b;
    logic         cin;
    logic [W-1:0] s_look, s_chain;
    logic         co_look, co_chain;

    logic [3:0] sa, sb, ss;
    logic       sc, sg, sp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    cla_adder16 #(.LOOKAHEAD_LINK(1'b1)) u_dut (
        .op_a(a), .op_b(b), .carry_in(cin), .sum(s_look), .carry_out(co_look)
    );

    cla_adder16 #(.LOOKAHEAD_LINK(1'b0)) u_chain (
        .op_a(a), .op_b(b), .carry_in(cin), .sum(s_chain), .carry_out(co_chain)
    );

    cla_slice #(.W(4)) u_slice (
        .a(sa), .b(sb), .c_in(sc), .s(ss), .slice_g(sg), .slice_p(sp)
    );

    // Apply one 16-bit vector and compare both variants to the integer total.
    task automatic apply16(input logic [W-1:0] va, input logic [W-1:0] vb,
                           input logic vc, input string tag);
        int exp_total;
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
        exp_total = int'(va) + int'(vb) + int'(vc);
        checks++;
        if (s_look !== exp_total[W-1:0]) begin
            fails++;
            $display("FAIL R1 %s: sum %h expected %h", tag, s_look, exp_total[W-1:0]);
        end
        checks++;
        if (co_look !== exp_total[W]) begin
            fails++;
            $display("FAIL R2 %s: carry_out %b expected %b", tag, co_look, exp_total[W]);
        end
        checks++;
        if ({co_chain, s_chain} !== {co_look, s_look}) begin
            fails++;
            $display("FAIL R5 %s: chained %b_%h expected %b_%h", tag,
                     co_chain, s_chain, exp_total[W], exp_total[W-1:0]);
        end
    endtask

    // Apply one slice vector: sum, propagate, generate, forced carry.
    task automatic apply4(input int va, input int vb, input int vc);
        int exp_s, exp_p, exp_g, exp_cout;
        @(posedge clk);
        sa = va[3:0]; sb = vb[3:0]; sc = vc[0];
        @(negedge clk);
        exp_s    = (va + vb + vc) % 16;
        exp_p    = ((va | vb) == 15) ? 1 : 0;
        exp_g    = ((va + vb) >= 16) ? 1 : 0;
        exp_cout = ((va + vb + vc) >= 16) ? 1 : 0;
        checks++;
        if ({sp, ss} !== {exp_p[0], exp_s[3:0]}) begin
            fails++;
            $display("FAIL R3 slice %0d+%0d+%0d: p,s %b,%h expected %b,%h",
                     va, vb, vc, sp, ss, exp_p[0], exp_s[3:0]);
        end
        checks++;
        if (sg !== exp_g[0] || (sg | (sp & sc)) !== exp_cout[0]) begin
            fails++;
            $display("FAIL R4 slice %0d+%0d+%0d: g %b cout %b expected g %b cout %b",
                     va, vb, vc, sg, sg | (sp & sc), exp_g[0], exp_cout[0]);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5ns * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        a = '0; b = '0; cin = 1'b0;
        sa = '0; sb = '0; sc = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({co_look, s_look} !== 17'h0) begin
            fails++;
            $display("FAIL R1 reset state: %b_%h expected 0_0000", co_look, s_look);
        end
        rst_n = 1'b1;

        // R3, R4: exhaustive slice sweep.
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++)
                    apply4(x, y, c);

        // R7: corner vectors.
        apply16(16'hFFFF, 16'h0000, 1'b1, "R7 all-ones+cin");
        apply16(16'hFFFF, 16'h0001, 1'b0, "R7 all-ones+1");
        apply16(16'hAAAA, 16'h5555, 1'b0, "R7 alternating");
        apply16(16'hAAAA, 16'h5555, 1'b1, "R7 alternating+cin");
        apply16(16'h5555, 16'h5555, 1'b0, "R7 alt doubled");
        apply16(16'hFFFF, 16'hFFFF, 1'b1, "R7 max+max+1");
        // R6: carry born in one slice crossing the others.
        apply16(16'h0FFF, 16'h0001, 1'b0, "R6 three-slice hop");
        apply16(16'hF0F0, 16'h0F10, 1'b0, "R6 mid hop");
        apply16(16'h8000, 16'h8000, 1'b0, "R6 top generate");
        apply16(16'h0000, 16'h0000, 1'b1, "R1 cin only");
        for (int i = 0; i < W; i++)
            apply16(16'(1 << i), 16'hFFFF >> (W - i), 1'b1, "R6 walking");

        // R1, R2, R5: random vectors.
        for (int i = 0; i < 3000; i++)
            apply16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule